// File: doc/BRIEF.md
# UART Receive/Transmit Byte Buffering with Fill-Level Interrupt

This block sits between the host register port of a 16550-style UART and its bit-level serializer. It holds received bytes in a receive queue and outgoing bytes in a transmit queue. It raises one interrupt request line. The serializer hands each received byte over with a one-cycle push. It takes each outgoing byte with a one-cycle pop, and it can see the head byte and whether one is available at any time.

The host controls the queues through a control register at offset 2, which is write-only. In queued mode both queues hold DEPTH bytes (16 by default). When queued mode is off, each queue is a single-byte holding register. The receive interrupt fires once the receive occupancy reaches a level the host picks. The transmit interrupt fires once each time the transmit queue drains, so sending a full queue costs one interrupt instead of one per byte. Reading offset 2 returns the interrupt identification, with the queued-mode flag in its two top bits.

Register offsets:
- 0: a read pops the receive queue; a write pushes the transmit queue.
- 2: a write sets the control register; a read returns the identification.
- 5: status.
- 7: scratch.
- Every other offset reads 0.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, identification (offset 2) reads 0x01, status (offset 5) reads 0x20, scratch reads 0x00, and `irq` is low.
- R2: A byte written to offset 7 reads back unchanged from offset 7.
- R3: Writing the control register with bit 0 set enables queued mode. Both queues then hold DEPTH bytes, and identification bits 7:6 read 11 (00 when disabled). Any change of bit 0 empties both queues.
- R4: Control bits 7:6 pick the receive level: 00→1, 01→4, 10→8, 11→14 bytes. In single-byte mode the level is 1. When receive occupancy reaches the level, identification bits 3:0 read 0x4 and `irq` is high.
- R5: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue. The action happens once and is not stored: a later control write without these bits leaves queued data in place.
- R6: In single-byte mode a second receive push, made before the first byte is read, is dropped, and the first byte is kept.
- R7: A receive push into a full buffer is dropped and sets the sticky overrun flag (status bit 1), which a status read clears. Status bit 0 is set while receive data is waiting, and bit 5 is set while the transmit buffer is empty.
- R8: When a pop empties the transmit buffer, identification bits 3:0 read 0x2 and `irq` goes high. This happens once per draining. It clears when the identification is read while showing 0x2, or when offset 0 is written.
- R9: Receive has priority over transmit in the identification. Bits 3:0 read 0x1 when nothing is pending, and `irq` is high exactly when something is pending.
- R10: Both queues are first-in first-out. `tx_byte` shows the transmit head while `tx_avail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| rx_push | input | 1 | Serializer delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Serializer takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte |
| tx_avail | output | 1 | Transmit buffer holds at least one byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: DEPTH of 16 and 8-bit bytes. The 17th receive push therefore hits a full queue, and the derived levels are 1, 4, 8 and 14, the exact values the requirements name. The sixteen-byte transmit drain shows a single interrupt at the last pop. Single-byte mode lets the same bench reach the overrun and holding-register paths with only two pushes.

// File: rtl/uart_fifo_pkg.sv
// Shared constants, identification codes and the trigger-level function
// for the UART byte buffering block.
package uart_fifo_pkg;

    localparam int BYTE_W = 8;

    // Register offsets on the host port
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IDCTL = 3'd2;
    localparam logic [2:0] OFS_STAT  = 3'd5;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    // Interrupt identification codes, low nibble
    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_TX   = 4'h2,
        IID_RX   = 4'h4
    } iid_e;

    // Receive fill level chosen by control bits 7:6, scaled to the depth
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
// Circular byte queue with a run-time capacity limit.
// Assumes DEPTH is a power of two, so the pointers wrap by overflow.
// A push into a full queue and a pop from an empty one are ignored.
// clr empties the queue and wins over a push or pop in the same cycle.
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             push,
    input  logic                             pop,
    input  logic [WIDTH-1:0]                 din,
    input  logic [$clog2(DEPTH+1)-1:0]       limit,
    output logic [WIDTH-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             full,
    output logic                             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count >= limit);
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Store the incoming byte at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

endmodule

// File: rtl/uart_int_ident.sv
// Interrupt identification: a prioritised code and the request line.
// Receive pending is a level (occupancy reaches the threshold).
// Transmit pending is latched by a drain event. It is released by an
// identification read that reported it, or by a transmit write.
module uart_int_ident #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_level,
    input  logic          tx_empty_evt,
    input  logic          tx_write,
    input  logic          iir_read,
    output logic [3:0]    iid,
    output logic          irq
);
    import uart_fifo_pkg::*;

    logic tx_pend_q;
    iid_e code;

    // Pick the highest-priority pending source
    always_comb begin
        if (rx_count >= rx_level) code = IID_RX;
        else if (tx_pend_q)       code = IID_TX;
        else                      code = IID_NONE;
    end

    assign iid = code;
    assign irq = (code != IID_NONE);

    // Latch the transmit-drained condition until it is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pend_q <= 1'b0;
        end else if (tx_empty_evt) begin
            tx_pend_q <= 1'b1;
        end else if (tx_write || (iir_read && code == IID_TX)) begin
            tx_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top of the UART byte buffering block.
// It decodes the host register port, holds the control, scratch and
// overrun state, and joins the two byte queues to the interrupt
// identification unit. Assumes the strobes last one cycle and that
// addr is stable while they are high.
module uart_fifo_ctrl #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       tx_pop,
    output logic [7:0] tx_byte,
    output logic       tx_avail,
    output logic       irq
);
    import uart_fifo_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic          fifo_en_q;
    logic [1:0]    trig_q;
    logic [7:0]    scr_q;
    logic          ovr_q;

    logic          wr_ctl, en_change, rx_clr, tx_clr;
    logic          rx_pop, tx_push, stat_read, iir_read;
    logic [CW-1:0] limit, rx_level;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0]    rx_dout;
    logic          tx_empty_evt;
    logic [3:0]    iid;

    assign wr_ctl    = wr_en && (addr == OFS_IDCTL);
    assign en_change = wr_ctl && (wdata[0] != fifo_en_q);
    assign rx_clr    = en_change || (wr_ctl && wdata[1]);
    assign tx_clr    = en_change || (wr_ctl && wdata[2]);
    assign rx_pop    = rd_en && (addr == OFS_DATA);
    assign tx_push   = wr_en && (addr == OFS_DATA);
    assign stat_read = rd_en && (addr == OFS_STAT);
    assign iir_read  = rd_en && (addr == OFS_IDCTL);

    assign limit    = fifo_en_q ? CW'(DEPTH) : CW'(1);
    assign rx_level = fifo_en_q ? CW'(trig_level(trig_q, DEPTH)) : CW'(1);

    // The pop that takes the last byte, with no accepted refill in that cycle
    assign tx_empty_evt = tx_pop && (tx_count == CW'(1))
                          && !(tx_push && !tx_full) && !tx_clr;
    assign tx_avail     = !tx_empty;

    // Control register: queued-mode enable and the receive level code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
            trig_q    <= 2'd0;
        end else if (wr_ctl) begin
            fifo_en_q <= wdata[0];
            trig_q    <= wdata[7:6];
        end
    end

    // Scratch register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q <= '0;
        end else if (wr_en && addr == OFS_SCR) begin
            scr_q <= wdata;
        end
    end

    // Sticky overrun: set by a push into a full buffer, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_push && rx_full) begin
            ovr_q <= 1'b1;
        end else if (stat_read) begin
            ovr_q <= 1'b0;
        end
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .pop   (rx_pop),
        .din   (rx_byte),
        .limit (limit),
        .dout  (rx_dout),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .pop   (tx_pop),
        .din   (wdata),
        .limit (limit),
        .dout  (tx_byte),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_int_ident #(.CW(CW)) u_ident (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_count     (rx_count),
        .rx_level     (rx_level),
        .tx_empty_evt (tx_empty_evt),
        .tx_write     (tx_push),
        .iir_read     (iir_read),
        .iid          (iid),
        .irq          (irq)
    );

    // Read-data multiplexer for the host port
    always_comb begin
        case (addr)
            OFS_DATA:  rdata = rx_dout;
            OFS_IDCTL: rdata = {fifo_en_q, fifo_en_q, 2'b00, iid};
            OFS_STAT:  rdata = {2'b00, tx_empty, 3'b000, ovr_q, !rx_empty};
            OFS_SCR:   rdata = scr_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Property checker for uart_fifo_ctrl, attached by bind below.
// It observes the occupancy, mode, level and overrun state of the top.
module uart_fifo_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en_q,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_level,
    input logic          rx_push,
    input logic          rx_full,
    input logic          ovr_q,
    input logic          irq,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [7:0]    wdata
);
    // Occupancy never exceeds the queue depth
    assert_rx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    // Single-byte mode never holds more than one byte per direction
    assert_single_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en_q |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

    // Reaching the receive level raises the request
    assert_rx_level_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= rx_level) |-> irq);

    // A push into a full buffer leaves overrun set
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_q);

    // A receive clear request empties the receive queue next cycle
    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && wdata[1]) |=> (rx_count == '0));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_q (fifo_en_q),
    .rx_count  (rx_count),
    .tx_count  (tx_count),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rx_full   (rx_full),
    .ovr_q     (ovr_q),
    .irq       (irq),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata)
);

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_avail;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(16)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail), .irq(irq)
    );

    // Vector fields: op[24:23] addr[22:20] data[19:12] expect[11:4] req[3:0]
    // op 0 write, 1 read and compare, 2 receive push, 3 compare tx head then pop
    localparam int NV = 28;
    localparam logic [24:0] VEC [NV] = '{
        {2'd1, 3'd2, 8'h00, 8'h01, 4'd1},  // R1 idle identification
        {2'd0, 3'd7, 8'hAA, 8'h00, 4'd2},  // R2 scratch write
        {2'd1, 3'd7, 8'h00, 8'hAA, 4'd2},  // R2 scratch read
        {2'd2, 3'd0, 8'h21, 8'h00, 4'd6},  // R6 first byte
        {2'd2, 3'd0, 8'h22, 8'h00, 4'd6},  // R6 second byte dropped
        {2'd1, 3'd2, 8'h00, 8'h04, 4'd4},  // R4 level 1 in single-byte mode
        {2'd1, 3'd5, 8'h00, 8'h23, 4'd7},  // R7 ready, overrun, tx empty
        {2'd1, 3'd5, 8'h00, 8'h21, 4'd7},  // R7 overrun cleared by read
        {2'd1, 3'd0, 8'h00, 8'h21, 4'd6},  // R6 first byte kept
        {2'd1, 3'd2, 8'h00, 8'h01, 4'd9},  // R9 nothing pending
        {2'd0, 3'd0, 8'h55, 8'h00, 4'd6},  // R6 tx hold
        {2'd0, 3'd0, 8'h66, 8'h00, 4'd6},  // R6 tx second write dropped
        {2'd3, 3'd0, 8'h00, 8'h55, 4'd6},  // R6 tx head kept
        {2'd1, 3'd2, 8'h00, 8'h02, 4'd8},  // R8 drained
        {2'd1, 3'd2, 8'h00, 8'h01, 4'd8},  // R8 cleared by identification read
        {2'd1, 3'd5, 8'h00, 8'h20, 4'd7},  // R7 status idle
        {2'd0, 3'd2, 8'h01, 8'h00, 4'd3},  // R3 enable queued mode, level 1
        {2'd1, 3'd2, 8'h00, 8'hC1, 4'd3},  // R3 top bits set
        {2'd2, 3'd0, 8'h31, 8'h00, 4'd10}, // R10
        {2'd2, 3'd0, 8'h32, 8'h00, 4'd10}, // R10
        {2'd1, 3'd2, 8'h00, 8'hC4, 4'd4},  // R4
        {2'd0, 3'd0, 8'h77, 8'h00, 4'd8},  // R8
        {2'd3, 3'd0, 8'h00, 8'h77, 4'd8},  // R8 drain while rx pending
        {2'd1, 3'd2, 8'h00, 8'hC4, 4'd9},  // R9 receive wins
        {2'd1, 3'd0, 8'h00, 8'h31, 4'd10}, // R10 order
        {2'd1, 3'd0, 8'h00, 8'h32, 4'd10}, // R10 order
        {2'd1, 3'd2, 8'h00, 8'hC2, 4'd9},  // R9 transmit shows after receive
        {2'd1, 3'd2, 8'h00, 8'hC1, 4'd8}   // R8 cleared
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] d);
        @(negedge clk); rx_byte = d; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, {7'd0, tx_avail}, 8'h01);
        check(req, tx_byte, exp);
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {7'd0, irq}, 8'h00);
        reg_rd(3'd5, v); check("R1 status", v, 8'h20);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            string tag;
            op  = VEC[i][24:23];
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            case (op)
                2'd0: reg_wr(VEC[i][22:20], VEC[i][19:12]);
                2'd1: begin reg_rd(VEC[i][22:20], v); check(tag, v, VEC[i][11:4]); end
                2'd2: rx_in(VEC[i][19:12]);
                default: tx_take(tag, VEC[i][11:4]);
            endcase
        end

        // R3 R7 R10: full queue, overrun on the extra push, order kept
        for (int i = 0; i < 17; i++) rx_in(8'h40 + 8'(i));
        reg_rd(3'd5, v); check("R7 full overrun", v, 8'h23);
        for (int i = 0; i < 16; i++) begin
            reg_rd(3'd0, v); check("R10 rx order", v, 8'h40 + 8'(i));
        end
        reg_rd(3'd5, v); check("R3 depth 16 drained", v, 8'h20);

        // R4 R5: levels 4, 8 and 14, clear request, no stored clear
        for (int c = 1; c < 4; c++) begin
            int lvl;
            lvl = (c == 1) ? 4 : (c == 2) ? 8 : 14;
            reg_wr(3'd2, 8'(c << 6) | 8'h01);
            for (int k = 0; k < lvl - 1; k++) rx_in(8'(k));
            check("R4 below level irq", {7'd0, irq}, 8'h00);
            reg_rd(3'd2, v); check("R4 below level id", v, 8'hC1);
            rx_in(8'hEE);
            check("R4 at level irq", {7'd0, irq}, 8'h01);
            reg_rd(3'd2, v); check("R4 at level id", v, 8'hC4);
            reg_wr(3'd2, 8'(c << 6) | 8'h03);
            check("R5 rx clear irq", {7'd0, irq}, 8'h00);
            reg_rd(3'd5, v); check("R5 rx cleared", v, 8'h20);
            rx_in(8'h99);
            reg_wr(3'd2, 8'(c << 6) | 8'h01);
            reg_rd(3'd5, v); check("R5 clear not stored", v, 8'h21);
            reg_rd(3'd0, v); check("R5 byte kept", v, 8'h99);
        end

        // R8: one interrupt per sixteen-byte drain
        reg_wr(3'd2, 8'h01);
        for (int i = 0; i < 16; i++) reg_wr(3'd0, 8'h80 + 8'(i));
        for (int i = 0; i < 16; i++) begin
            tx_take("R10 tx order", 8'h80 + 8'(i));
            check("R8 irq per drain", {7'd0, irq}, (i == 15) ? 8'h01 : 8'h00);
        end
        reg_rd(3'd2, v); check("R8 drained id", v, 8'hC2);
        check("R8 cleared by read", {7'd0, irq}, 8'h00);
        reg_wr(3'd0, 8'h5A);
        tx_take("R8 single", 8'h5A);
        check("R8 raised again", {7'd0, irq}, 8'h01);
        reg_wr(3'd0, 8'hA5);
        check("R8 cleared by write", {7'd0, irq}, 8'h00);

        // R5: transmit clear request
        reg_wr(3'd2, 8'h05);
        check("R5 tx clear avail", {7'd0, tx_avail}, 8'h00);
        check("R5 tx clear no irq", {7'd0, irq}, 8'h00);

        // R3: leaving queued mode empties both queues
        rx_in(8'h11); rx_in(8'h12); reg_wr(3'd0, 8'h13);
        reg_wr(3'd2, 8'h00);
        reg_rd(3'd5, v); check("R3 disable empties", v, 8'h20);
        reg_rd(3'd2, v); check("R3 top bits clear", v, 8'h01);

        // R1: reset in mid-run
        reg_wr(3'd7, 8'h3C); reg_wr(3'd2, 8'h01); rx_in(8'h44); reg_wr(3'd0, 8'h45);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        reg_rd(3'd2, v); check("R1 id after reset", v, 8'h01);
        reg_rd(3'd5, v); check("R1 status after reset", v, 8'h20);
        reg_rd(3'd7, v); check("R1 scratch after reset", v, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule